// File: doc/BRIEF.md
# Sharing-List Node Coherence Controller

This block is the coherence controller for one cache line at one processor node in a directory-based system. Each node that caches the line is an entry in a doubly linked list. The directory's home node only records which node is the list's head. The controller holds the line's 7-bit state code and two node-ID links. The forward link points toward the tail of the list and the backward link points toward the head. Both links reset to a null ID.

A local processor request to fetch the line goes to the home node. If the home node names an existing head, the controller then asks that node to step down. While any of its own transactions is open, the controller refuses every request arriving from other nodes with a busy answer, and the sender retries. This is how it stays safe against races such as an invalidation arriving before the data reply, without relying on a shared bus to order events.

A write to a shared line takes effect at once. The head then removes every other copy by walking the forward links with purge requests. A programmable timeout ends any transaction that receives no reply.

Top module: `sl_node_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `line_state` is 7'h00 (invalid), `fwd_ptr` and `back_ptr` hold the null ID (all ones), and `pending`, `out_valid`, `in_rsp_valid` and `tmo_fail` are 0.
- R2: The line state codes are: invalid 7'h00, ONLY_FRESH 7'h10, ONLY_DIRTY 7'h11, HEAD_FRESH 7'h20, HEAD_DIRTY 7'h21, MID_VALID 7'h30 and TAIL_VALID 7'h38. A code outside this set is treated as invalid. When the home node's reply names no head (`rsp_node` is the null ID), the fetch completes as follows: a read fetch gives ONLY_FRESH, a read/write fetch gives ONLY_DIRTY, and both links become null.
- R3: Suppose the controller is idle, the line is invalid, and `cpu_valid` arrives with `cpu_op` 0 (read fetch) or 1 (read/write fetch). In the next cycle the controller drives `out_valid` for one cycle, with `out_kind` equal to `cpu_op` and `out_dest` set to the home ID. `pending` rises in that same cycle. `out_valid` is never high while `pending` is low.
- R4: Suppose the home node's reply names a head node H. The controller sets `fwd_ptr` to H and sends a demote request (`out_kind` 2) to H in the next cycle. A non-busy reply to that request completes the fetch: a read fetch gives HEAD_FRESH, a read/write fetch gives HEAD_DIRTY, and `back_ptr` stays null.
- R5: A reply with `rsp_busy` = 1 makes the controller resend the same request, with the same kind and destination, in the next cycle. The line state and links do not change.
- R6: While `pending` is high, every incoming request is answered with `in_rsp_valid` = 1 and `in_rsp_busy` = 1 in the next cycle. The line state and links do not change.
- R7: Suppose an incoming demote request (`in_req_purge` = 0) arrives while the controller is idle and the line is ONLY_* or HEAD_*. `back_ptr` becomes the requester's ID. The state becomes TAIL_VALID if `fwd_ptr` is null, otherwise MID_VALID. A non-busy answer follows in the next cycle. A demote request in any other state gets a non-busy answer and changes nothing.
- R8: Suppose an incoming purge request (`in_req_purge` = 1) arrives while the controller is idle and the line is MID_VALID or TAIL_VALID. The line becomes invalid and both links become null. A non-busy answer follows in the next cycle, with `in_rsp_next` equal to the old `fwd_ptr`. In any other state a purge request changes nothing, and `in_rsp_next` is null.
- R9: A local write (`cpu_op` 2) affects the line as follows. On ONLY_FRESH it gives ONLY_DIRTY and sends no request. On HEAD_* it sets HEAD_DIRTY at once and sends a purge request (`out_kind` 2'd3) to `fwd_ptr`. Each non-busy purge reply then does one of two things. If it names a node, that node becomes `fwd_ptr` and receives the next purge. If it names the null ID, the walk ends: `fwd_ptr` becomes null and the state becomes ONLY_DIRTY.
- R10: Suppose no reply arrives by the `tmo_limit`-th clock edge after the most recent request was sent (`tmo_limit` ≥ 2). The transaction ends at that edge and `tmo_fail` pulses for one cycle as `pending` falls. Every resend restarts the count. An aborted fetch leaves the line invalid with both links null. An aborted purge walk keeps HEAD_DIRTY and the current `fwd_ptr`.
- R11: A local request is ignored in three cases: while `pending` is high, when it does not apply to the current state, and when an incoming request arrives in the same cycle. In the third case the incoming request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_limit | input | TMO_W | Timeout length in clock edges (typically 1024) |
| cpu_valid | input | 1 | Local processor request strobe |
| cpu_op | input | 2 | 0 read fetch, 1 read/write fetch, 2 write to line |
| out_valid | output | 1 | Outgoing request strobe |
| out_kind | output | 2 | 0 read fetch, 1 read/write fetch, 2 demote, 3 purge |
| out_dest | output | NODE_W | Destination node ID of the outgoing request |
| rsp_valid | input | 1 | Reply to the outstanding request |
| rsp_busy | input | 1 | Reply says the target was busy; retry |
| rsp_node | input | NODE_W | Head ID (fetch reply) or next node ID (purge reply); all ones means none |
| in_req_valid | input | 1 | Request from another node |
| in_req_purge | input | 1 | 1 purge, 0 demote |
| in_req_src | input | NODE_W | ID of the requesting node |
| in_rsp_valid | output | 1 | Answer to an incoming request |
| in_rsp_busy | output | 1 | Answer is busy; requester must retry |
| in_rsp_next | output | NODE_W | Forward link given up by a purged node, else null |
| line_state | output | 7 | Line state code |
| fwd_ptr | output | NODE_W | Forward link (toward tail) |
| back_ptr | output | NODE_W | Backward link (toward head) |
| pending | output | 1 | Own transaction outstanding |
| tmo_fail | output | 1 | One-cycle pulse when a transaction times out |

## Verification
The hardest case is a busy reply to a demote request followed by silence. It shows whether the timeout restarts on a resend rather than counting from the first send. It only arises when the bench, acting as home node and old head, first returns busy and then withholds any reply for exactly the limit. The stimulus scripts that responder behaviour directly, and it also sends an outside demote request into the pending window. A second hard case is a local request and an incoming request landing on the same edge, which the stimulus produces by raising both strobes in one cycle while the controller is idle.

// File: rtl/sl_node_pkg.sv
// Shared encodings and helpers for the sharing-list node controller.
// Assumes: node IDs of all ones mean "no node" (null link).
package sl_node_pkg;
    localparam int LS_W = 7;
    typedef logic [LS_W-1:0] lstate_t;

    localparam lstate_t LS_INVALID    = 7'h00;
    localparam lstate_t LS_ONLY_FRESH = 7'h10;
    localparam lstate_t LS_ONLY_DIRTY = 7'h11;
    localparam lstate_t LS_HEAD_FRESH = 7'h20;
    localparam lstate_t LS_HEAD_DIRTY = 7'h21;
    localparam lstate_t LS_MID_VALID  = 7'h30;
    localparam lstate_t LS_TAIL_VALID = 7'h38;

    localparam logic [1:0] CPU_RD  = 2'd0;
    localparam logic [1:0] CPU_RW  = 2'd1;
    localparam logic [1:0] CPU_MOD = 2'd2;

    typedef enum logic [1:0] {
        RQ_FETCH_R  = 2'd0,
        RQ_FETCH_RW = 2'd1,
        RQ_DEMOTE   = 2'd2,
        RQ_PURGE    = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HOME   = 2'd1,
        PH_DEMOTE = 2'd2,
        PH_PURGE  = 2'd3
    } phase_e;

    // Map any unrecognised code to invalid.
    function automatic lstate_t canon(input lstate_t s);
        case (s)
            LS_ONLY_FRESH, LS_ONLY_DIRTY, LS_HEAD_FRESH, LS_HEAD_DIRTY,
            LS_MID_VALID, LS_TAIL_VALID: return s;
            default: return LS_INVALID;
        endcase
    endfunction

    // True for the states that own the line (list head or sole copy).
    function automatic logic is_owner(input lstate_t s);
        return (s == LS_ONLY_FRESH) || (s == LS_ONLY_DIRTY) ||
               (s == LS_HEAD_FRESH) || (s == LS_HEAD_DIRTY);
    endfunction

    // True for the states that sit behind the head.
    function automatic logic is_sharer(input lstate_t s);
        return (s == LS_MID_VALID) || (s == LS_TAIL_VALID);
    endfunction

    // True for the states that head a list of two or more.
    function automatic logic is_head(input lstate_t s);
        return (s == LS_HEAD_FRESH) || (s == LS_HEAD_DIRTY);
    endfunction
endpackage

// File: rtl/sl_txn_timer.sv
// Transaction timeout counter.
// Counts clock edges since the latest request was sent; raises expire on
// the edge that would reach the limit with no reply present.
// Assumes: limit >= 2 and held constant while a transaction is open.
module sl_txn_timer #(
    parameter int TMO_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] limit,
    input  logic             restart,
    input  logic             waiting,
    input  logic             rsp_seen,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;

    // Expiry happens when the count would reach the limit this edge.
    always_comb begin
        expire = waiting && !rsp_seen && (cnt_q == (limit - 1'b1));
    end

    // Clear on each send, advance while a reply is awaited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (waiting && !rsp_seen && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_cnt_below_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (cnt_q < limit));
endmodule

// File: rtl/sl_snoop_resp.sv
// Responder for requests arriving from other nodes.
// Decides whether an incoming demote or purge applies to this line and
// answers every request one cycle later, busy when a transaction is open.
// Assumes: at most one incoming request per cycle.
module sl_snoop_resp
    import sl_node_pkg::*;
#(
    parameter int NODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req_valid,
    input  logic              in_req_purge,
    input  logic              pending,
    input  lstate_t           line_state,
    input  logic [NODE_W-1:0] fwd_ptr,
    output logic              apply_demote,
    output logic              apply_purge,
    output logic              in_rsp_valid,
    output logic              in_rsp_busy,
    output logic [NODE_W-1:0] in_rsp_next
);
    localparam logic [NODE_W-1:0] NULL_ID = '1;

    lstate_t cur;

    // Decide whether the request acts on the line this cycle.
    always_comb begin
        cur          = canon(line_state);
        apply_demote = in_req_valid && !pending && !in_req_purge && is_owner(cur);
        apply_purge  = in_req_valid && !pending &&  in_req_purge && is_sharer(cur);
    end

    // Register the answer, including the link handed back on a purge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_rsp_valid <= 1'b0;
            in_rsp_busy  <= 1'b0;
            in_rsp_next  <= NULL_ID;
        end else begin
            in_rsp_valid <= in_req_valid;
            in_rsp_busy  <= in_req_valid && pending;
            in_rsp_next  <= apply_purge ? fwd_ptr : NULL_ID;
        end
    end

    p_busy_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req_valid && pending) |=> (in_rsp_valid && in_rsp_busy));
    p_idle_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req_valid && !pending) |=> (in_rsp_valid && !in_rsp_busy));
endmodule

// File: rtl/sl_txn_seq.sv
// Transaction sequencer and line registers.
// Runs fetch, demote and purge-walk transactions, applies local writes,
// applies incoming demote/purge decisions and handles busy and timeout.
// Assumes: apply_demote/apply_purge are only raised while not pending.
module sl_txn_seq
    import sl_node_pkg::*;
#(
    parameter int NODE_W  = 4,
    parameter int HOME_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic              in_req_valid,
    input  logic [NODE_W-1:0] in_req_src,
    input  logic              apply_demote,
    input  logic              apply_purge,
    input  logic              rsp_valid,
    input  logic              rsp_busy,
    input  logic [NODE_W-1:0] rsp_node,
    input  logic              expire,
    output logic              send,
    output logic              pending,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [NODE_W-1:0] out_dest,
    output lstate_t           line_state,
    output logic [NODE_W-1:0] fwd_ptr,
    output logic [NODE_W-1:0] back_ptr,
    output logic              tmo_fail
);
    localparam logic [NODE_W-1:0] NULL_ID = '1;
    localparam logic [NODE_W-1:0] HOME    = NODE_W'(HOME_ID);

    phase_e            ph_q, ph_n;
    lstate_t           st_q, st_n, cur;
    logic [NODE_W-1:0] fwd_q, fwd_n, back_q, back_n, dest_q, dest_n;
    req_kind_e         kind_q, kind_n;
    logic              rw_q, rw_n, tmo_n;

    // Next-state decision for line, links and the open transaction.
    always_comb begin
        cur    = canon(st_q);
        ph_n   = ph_q;
        st_n   = st_q;
        fwd_n  = fwd_q;
        back_n = back_q;
        kind_n = kind_q;
        dest_n = dest_q;
        rw_n   = rw_q;
        send   = 1'b0;
        tmo_n  = 1'b0;
        if (apply_demote) begin
            back_n = in_req_src;
            st_n   = (fwd_q == NULL_ID) ? LS_TAIL_VALID : LS_MID_VALID;
        end else if (apply_purge) begin
            st_n   = LS_INVALID;
            fwd_n  = NULL_ID;
            back_n = NULL_ID;
        end else if (ph_q == PH_IDLE) begin
            if (cpu_valid && !in_req_valid) begin
                if ((cpu_op == CPU_RD || cpu_op == CPU_RW) && cur == LS_INVALID) begin
                    rw_n   = (cpu_op == CPU_RW);
                    kind_n = (cpu_op == CPU_RW) ? RQ_FETCH_RW : RQ_FETCH_R;
                    dest_n = HOME;
                    send   = 1'b1;
                    ph_n   = PH_HOME;
                end else if (cpu_op == CPU_MOD && cur == LS_ONLY_FRESH) begin
                    st_n = LS_ONLY_DIRTY;
                end else if (cpu_op == CPU_MOD && is_head(cur)) begin
                    st_n   = LS_HEAD_DIRTY;
                    kind_n = RQ_PURGE;
                    dest_n = fwd_q;
                    send   = 1'b1;
                    ph_n   = PH_PURGE;
                end
            end
        end else if (rsp_valid) begin
            if (rsp_busy) begin
                send = 1'b1;
            end else begin
                case (ph_q)
                    PH_HOME: begin
                        if (rsp_node == NULL_ID) begin
                            st_n   = rw_q ? LS_ONLY_DIRTY : LS_ONLY_FRESH;
                            fwd_n  = NULL_ID;
                            back_n = NULL_ID;
                            ph_n   = PH_IDLE;
                        end else begin
                            fwd_n  = rsp_node;
                            kind_n = RQ_DEMOTE;
                            dest_n = rsp_node;
                            send   = 1'b1;
                            ph_n   = PH_DEMOTE;
                        end
                    end
                    PH_DEMOTE: begin
                        st_n   = rw_q ? LS_HEAD_DIRTY : LS_HEAD_FRESH;
                        back_n = NULL_ID;
                        ph_n   = PH_IDLE;
                    end
                    default: begin
                        if (rsp_node == NULL_ID) begin
                            fwd_n = NULL_ID;
                            st_n  = LS_ONLY_DIRTY;
                            ph_n  = PH_IDLE;
                        end else begin
                            fwd_n  = rsp_node;
                            dest_n = rsp_node;
                            send   = 1'b1;
                        end
                    end
                endcase
            end
        end else if (expire) begin
            tmo_n = 1'b1;
            ph_n  = PH_IDLE;
            if (ph_q != PH_PURGE) begin
                st_n   = LS_INVALID;
                fwd_n  = NULL_ID;
                back_n = NULL_ID;
            end
        end
    end

    // Register the line, links, phase and outgoing request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            st_q      <= LS_INVALID;
            fwd_q     <= NULL_ID;
            back_q    <= NULL_ID;
            kind_q    <= RQ_FETCH_R;
            dest_q    <= NULL_ID;
            rw_q      <= 1'b0;
            out_valid <= 1'b0;
            tmo_fail  <= 1'b0;
        end else begin
            ph_q      <= ph_n;
            st_q      <= st_n;
            fwd_q     <= fwd_n;
            back_q    <= back_n;
            kind_q    <= kind_n;
            dest_q    <= dest_n;
            rw_q      <= rw_n;
            out_valid <= send;
            tmo_fail  <= tmo_n;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        pending    = (ph_q != PH_IDLE);
        out_kind   = kind_q;
        out_dest   = dest_q;
        line_state = st_q;
        fwd_ptr    = fwd_q;
        back_ptr   = back_q;
    end

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> !out_valid);
    p_fetch_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind[1] == 1'b0) |-> (out_dest == HOME));
    p_tmo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fail |-> !pending);
    p_owner_back_null_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_owner(st_q) |-> (back_q == NULL_ID));
    p_only_fwd_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_ONLY_FRESH || st_q == LS_ONLY_DIRTY) |-> (fwd_q == NULL_ID));
    p_known_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (canon(st_q) == st_q));
endmodule

// File: rtl/sl_node_ctrl.sv
// Sharing-list node coherence controller for one cache line.
// Joins the sequencer, the incoming-request responder and the timeout
// counter. Assumes the network delivers at most one reply and one
// incoming request per cycle.
module sl_node_ctrl
    import sl_node_pkg::*;
#(
    parameter int NODE_W  = 4,
    parameter int HOME_ID = 0,
    parameter int TMO_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [NODE_W-1:0] out_dest,
    input  logic              rsp_valid,
    input  logic              rsp_busy,
    input  logic [NODE_W-1:0] rsp_node,
    input  logic              in_req_valid,
    input  logic              in_req_purge,
    input  logic [NODE_W-1:0] in_req_src,
    output logic              in_rsp_valid,
    output logic              in_rsp_busy,
    output logic [NODE_W-1:0] in_rsp_next,
    output logic [6:0]        line_state,
    output logic [NODE_W-1:0] fwd_ptr,
    output logic [NODE_W-1:0] back_ptr,
    output logic              pending,
    output logic              tmo_fail
);
    logic apply_demote, apply_purge, send, expire;

    sl_snoop_resp #(.NODE_W(NODE_W)) u_snoop (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_req_valid (in_req_valid),
        .in_req_purge (in_req_purge),
        .pending      (pending),
        .line_state   (line_state),
        .fwd_ptr      (fwd_ptr),
        .apply_demote (apply_demote),
        .apply_purge  (apply_purge),
        .in_rsp_valid (in_rsp_valid),
        .in_rsp_busy  (in_rsp_busy),
        .in_rsp_next  (in_rsp_next)
    );

    sl_txn_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit    (tmo_limit),
        .restart  (send),
        .waiting  (pending),
        .rsp_seen (rsp_valid),
        .expire   (expire)
    );

    sl_txn_seq #(.NODE_W(NODE_W), .HOME_ID(HOME_ID)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_valid    (cpu_valid),
        .cpu_op       (cpu_op),
        .in_req_valid (in_req_valid),
        .in_req_src   (in_req_src),
        .apply_demote (apply_demote),
        .apply_purge  (apply_purge),
        .rsp_valid    (rsp_valid),
        .rsp_busy     (rsp_busy),
        .rsp_node     (rsp_node),
        .expire       (expire),
        .send         (send),
        .pending      (pending),
        .out_valid    (out_valid),
        .out_kind     (out_kind),
        .out_dest     (out_dest),
        .line_state   (line_state),
        .fwd_ptr      (fwd_ptr),
        .back_ptr     (back_ptr),
        .tmo_fail     (tmo_fail)
    );
endmodule

// File: tb/sl_node_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks tagged by requirement.
module sl_node_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW   = 4;
    localparam int NULLI = 15;
    localparam int HOMEI = 0;
    localparam int LIM  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [10:0] tmo_limit = 11'(LIM);
    logic cpu_valid = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic out_valid;
    logic [1:0] out_kind;
    logic [NW-1:0] out_dest;
    logic rsp_valid = 1'b0, rsp_busy = 1'b0;
    logic [NW-1:0] rsp_node = '0;
    logic in_req_valid = 1'b0, in_req_purge = 1'b0;
    logic [NW-1:0] in_req_src = '0;
    logic in_rsp_valid, in_rsp_busy;
    logic [NW-1:0] in_rsp_next;
    logic [6:0] line_state;
    logic [NW-1:0] fwd_ptr, back_ptr;
    logic pending, tmo_fail;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;

    sl_node_ctrl u_sl_node_ctrl (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
        .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .rsp_node(rsp_node),
        .in_req_valid(in_req_valid), .in_req_purge(in_req_purge), .in_req_src(in_req_src),
        .in_rsp_valid(in_rsp_valid), .in_rsp_busy(in_rsp_busy), .in_rsp_next(in_rsp_next),
        .line_state(line_state), .fwd_ptr(fwd_ptr), .back_ptr(back_ptr),
        .pending(pending), .tmo_fail(tmo_fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model state
    int m_state, m_fwd, m_back, m_phase, m_rw, m_outv, m_kind, m_dest;
    int m_cnt, m_tmo, m_rv, m_rb, m_rn;

    always @(posedge clk) begin
        int s, f, pend, send, abort;
        started = 1;
        if (!rst_n) begin
            m_state = 0; m_fwd = NULLI; m_back = NULLI; m_phase = 0; m_rw = 0;
            m_outv = 0; m_kind = 0; m_dest = NULLI; m_cnt = 0; m_tmo = 0;
            m_rv = 0; m_rb = 0; m_rn = NULLI;
        end else begin
            s = m_state; f = m_fwd; pend = (m_phase != 0);
            send = 0; abort = 0;
            m_rv = in_req_valid; m_rb = in_req_valid && pend; m_rn = NULLI;
            if (in_req_valid && !pend) begin
                if (!in_req_purge && (s == 'h10 || s == 'h11 || s == 'h20 || s == 'h21)) begin
                    m_back = in_req_src;
                    m_state = (f == NULLI) ? 'h38 : 'h30;
                end else if (in_req_purge && (s == 'h30 || s == 'h38)) begin
                    m_rn = f; m_state = 0; m_fwd = NULLI; m_back = NULLI;
                end
            end else if (!pend) begin
                if (cpu_valid) begin
                    if ((cpu_op == 0 || cpu_op == 1) && s == 0) begin
                        m_rw = cpu_op; m_kind = cpu_op; m_dest = HOMEI; send = 1; m_phase = 1;
                    end else if (cpu_op == 2 && s == 'h10) begin
                        m_state = 'h11;
                    end else if (cpu_op == 2 && (s == 'h20 || s == 'h21)) begin
                        m_state = 'h21; m_kind = 3; m_dest = f; send = 1; m_phase = 3;
                    end
                end
            end else if (rsp_valid) begin
                if (rsp_busy) send = 1;
                else if (m_phase == 1) begin
                    if (rsp_node == NULLI) begin
                        m_state = m_rw ? 'h11 : 'h10; m_fwd = NULLI; m_back = NULLI; m_phase = 0;
                    end else begin
                        m_fwd = rsp_node; m_kind = 2; m_dest = rsp_node; send = 1; m_phase = 2;
                    end
                end else if (m_phase == 2) begin
                    m_state = m_rw ? 'h21 : 'h20; m_back = NULLI; m_phase = 0;
                end else begin
                    if (rsp_node == NULLI) begin
                        m_fwd = NULLI; m_state = 'h11; m_phase = 0;
                    end else begin
                        m_fwd = rsp_node; m_dest = rsp_node; send = 1;
                    end
                end
            end else if (m_cnt == LIM - 1) begin
                abort = 1;
                if (m_phase != 3) begin m_state = 0; m_fwd = NULLI; m_back = NULLI; end
                m_phase = 0;
            end
            if (send) m_cnt = 0;
            else if (pend && !rsp_valid && !abort) m_cnt++;
            m_outv = send;
            m_tmo = abort;
        end
    end

    // Compare every cycle, and run the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (started) begin
            chk("R2", "line_state", int'(line_state), m_state);
            chk("R4", "fwd_ptr", int'(fwd_ptr), m_fwd);
            chk("R7", "back_ptr", int'(back_ptr), m_back);
            chk("R3", "pending", int'(pending), int'(m_phase != 0));
            chk("R3", "out_valid", int'(out_valid), m_outv);
            if (m_outv != 0) begin
                chk("R3", "out_kind", int'(out_kind), m_kind);
                chk("R3", "out_dest", int'(out_dest), m_dest);
            end
            chk("R6", "in_rsp_valid", int'(in_rsp_valid), m_rv);
            chk("R6", "in_rsp_busy", int'(in_rsp_busy), m_rb);
            chk("R8", "in_rsp_next", int'(in_rsp_next), m_rn);
            chk("R10", "tmo_fail", int'(tmo_fail), m_tmo);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R10 watchdog act=%0d exp=%0d", cycles, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu(input int op);
        cpu_valid = 1'b1; cpu_op = 2'(op);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic inreq(input bit purge, input int src);
        in_req_valid = 1'b1; in_req_purge = purge; in_req_src = NW'(src);
        @(negedge clk);
        in_req_valid = 1'b0;
    endtask

    task automatic reply(input bit busy, input int node);
        rsp_valid = 1'b1; rsp_busy = busy; rsp_node = NW'(node);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_busy = 1'b0;
    endtask

    initial begin
        idle(3);
        chk("R1", "line_state", int'(line_state), 0);
        chk("R1", "fwd_ptr", int'(fwd_ptr), NULLI);
        chk("R1", "back_ptr", int'(back_ptr), NULLI);
        chk("R1", "pending", int'(pending), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        idle(1);

        // Read fetch, no existing head
        cpu(0);
        chk("R3", "out_valid", int'(out_valid), 1);
        chk("R3", "out_kind", int'(out_kind), 0);
        chk("R3", "out_dest", int'(out_dest), HOMEI);
        chk("R3", "pending", int'(pending), 1);
        idle(1);
        reply(0, NULLI);
        chk("R2", "only_fresh", int'(line_state), 'h10);
        chk("R2", "pending", int'(pending), 0);

        // Purge on an owner is ignored; demote then purge
        inreq(1, 2);
        chk("R8", "purge ignored state", int'(line_state), 'h10);
        chk("R8", "purge ignored next", int'(in_rsp_next), NULLI);
        inreq(0, 5);
        chk("R7", "tail", int'(line_state), 'h38);
        chk("R7", "back", int'(back_ptr), 5);
        chk("R7", "not busy", int'(in_rsp_busy), 0);
        inreq(1, 2);
        chk("R8", "invalid", int'(line_state), 0);
        chk("R8", "next null", int'(in_rsp_next), NULLI);

        // Read/write fetch with existing head 3, busy window, retry
        cpu(1);
        chk("R3", "rw kind", int'(out_kind), 1);
        reply(0, 3);
        chk("R4", "demote kind", int'(out_kind), 2);
        chk("R4", "demote dest", int'(out_dest), 3);
        chk("R4", "fwd", int'(fwd_ptr), 3);
        inreq(0, 9);
        chk("R6", "busy valid", int'(in_rsp_valid), 1);
        chk("R6", "busy", int'(in_rsp_busy), 1);
        chk("R6", "state kept", int'(line_state), 0);
        reply(1, 0);
        chk("R5", "resend", int'(out_valid), 1);
        chk("R5", "resend dest", int'(out_dest), 3);
        idle(1);
        reply(0, 0);
        chk("R4", "head_dirty", int'(line_state), 'h21);
        chk("R4", "back null", int'(back_ptr), NULLI);

        // Demoted with a forward link -> MID, then purged
        inreq(0, 6);
        chk("R7", "mid", int'(line_state), 'h30);
        chk("R7", "back", int'(back_ptr), 6);
        inreq(1, 1);
        chk("R8", "next", int'(in_rsp_next), 3);
        chk("R8", "invalid", int'(line_state), 0);

        // HEAD_FRESH then a write with a purge walk
        cpu(0);
        reply(0, 4);
        reply(0, 0);
        chk("R4", "head_fresh", int'(line_state), 'h20);
        cpu(2);
        chk("R9", "head_dirty now", int'(line_state), 'h21);
        chk("R9", "purge kind", int'(out_kind), 3);
        chk("R9", "purge dest", int'(out_dest), 4);
        reply(0, 7);
        chk("R9", "next purge dest", int'(out_dest), 7);
        chk("R9", "fwd", int'(fwd_ptr), 7);
        reply(1, 0);
        chk("R5", "purge resend dest", int'(out_dest), 7);
        reply(0, NULLI);
        chk("R9", "only_dirty", int'(line_state), 'h11);
        chk("R9", "fwd null", int'(fwd_ptr), NULLI);

        // Write on ONLY_DIRTY ignored; ONLY_FRESH write upgrades silently
        cpu(2);
        chk("R11", "no request", int'(out_valid), 0);
        inreq(0, 2);
        inreq(1, 2);
        cpu(0);
        reply(0, NULLI);
        cpu(2);
        chk("R9", "upgrade", int'(line_state), 'h11);
        chk("R9", "no request", int'(out_valid), 0);

        // Timeout of a fetch
        inreq(0, 2);
        inreq(1, 2);
        cpu(1);
        idle(LIM - 1);
        chk("R10", "still pending", int'(pending), 1);
        idle(1);
        chk("R10", "tmo pulse", int'(tmo_fail), 1);
        chk("R10", "released", int'(pending), 0);
        chk("R10", "invalid", int'(line_state), 0);
        idle(1);
        chk("R10", "pulse ends", int'(tmo_fail), 0);

        // Resend restarts the count
        cpu(0);
        reply(0, 3);
        idle(3);
        reply(1, 0);
        idle(LIM - 1);
        chk("R10", "restart pending", int'(pending), 1);
        idle(1);
        chk("R10", "restart tmo", int'(tmo_fail), 1);
        chk("R10", "fwd cleared", int'(fwd_ptr), NULLI);

        // Purge walk timeout keeps HEAD_DIRTY
        cpu(0);
        reply(0, 4);
        reply(0, 0);
        cpu(2);
        idle(LIM);
        chk("R10", "purge tmo", int'(tmo_fail), 1);
        chk("R10", "keeps head_dirty", int'(line_state), 'h21);
        chk("R10", "keeps fwd", int'(fwd_ptr), 4);

        // Local request while pending is ignored
        cpu(2);
        cpu(0);
        chk("R11", "ignored while pending", int'(out_valid), 0);
        reply(0, NULLI);
        chk("R9", "walk done", int'(line_state), 'h11);

        // Collision: incoming served, local dropped
        inreq(0, 2);
        inreq(1, 2);
        cpu_valid = 1'b1; cpu_op = 2'd0;
        in_req_valid = 1'b1; in_req_purge = 1'b1; in_req_src = 4'd2;
        @(negedge clk);
        cpu_valid = 1'b0; in_req_valid = 1'b0;
        chk("R11", "local dropped", int'(out_valid), 0);
        chk("R11", "not pending", int'(pending), 0);
        chk("R11", "answered", int'(in_rsp_valid), 1);
        chk("R11", "not busy", int'(in_rsp_busy), 0);

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule